// File: doc/BRIEF.md
# Serial Audio Sample Transmitter

This block takes a stream of 8-bit audio samples and sends each one along two paths. The first is a parallel DAC sample register, updated on a rate strobe. The second is a one-pin serial output. A small shared buffer holds each accepted sample until both paths have taken it. Each path reads the buffer at its own pace, so the two paths stay in step on content but not on timing.

The serial path sends a fixed frame: a start bit (0), eight data bits sent LSB first, and a stop bit (1). The configuration selects where bit timing comes from:
- Asynchronous mode uses an internal divider.
- Synchronous mode uses an external bit clock, and the configuration selects its active edge.

An active-low request-to-send input allows a new frame to start only at a frame boundary. The pin can be driven push-pull or open-drain.

An active-low suspend input freezes the DAC path only. A toggle output marks every DAC update.

Top module: `serial_audio_tx`

## Requirements
- R1: While reset is held, the pin reads 1 (push-pull drives 1 with the output enable high), the DAC sample register and the sync output are 0, and the sample input is ready.
- R2: Every frame is one 0 start bit, then the 8 data bits from bit 0 to bit 7, then one 1 stop bit, with each bit on the line for one bit interval.
- R3: In asynchronous mode (cfg_async_i=1), every change on the line falls on a boundary of a bit interval of cfg_baud_div_i+1 clock cycles.
- R4: In synchronous mode, the line changes only within 4 clock cycles after an active edge of bclk_i. The active edge is rising when cfg_fall_edge_i=0 and falling when cfg_fall_edge_i=1.
- R5: A frame starts only when rts_ni was low at the frame boundary. Raising rts_ni during a frame lets that frame complete and holds off the next one.
- R6: With cfg_open_drain_i=1, txd_o is 0 and txd_oe_o is high for a 0 bit, and txd_oe_o is low for a 1 bit. With cfg_open_drain_i=0, txd_oe_o is high and txd_o carries the line.
- R7: The serial frames and the DAC updates each carry every accepted sample exactly once, in order of acceptance.
- R8: While susp_ni is low, dac_tick_i is ignored and dac_sample_o holds. Serial frames keep flowing. Once susp_ni is high again, updates resume with the next sample not yet shown.
- R9: dac_sync_o toggles exactly once for each DAC update, one cycle after a dac_tick_i with susp_ni high and a sample pending. It changes at no other time.
- R10: With no sample pending for the serial path, the line idles at 1.
- R11: smp_ready_o is low while either path has DEPTH (default 8) accepted samples it has not yet consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample offered |
| smp_data_i | input | SMP_W | Sample value |
| smp_ready_o | output | 1 | Sample accepted when high with valid |
| cfg_async_i | input | 1 | 1: internal divider timing, 0: external bit clock |
| cfg_fall_edge_i | input | 1 | Synchronous mode active edge: 0 rising, 1 falling |
| cfg_open_drain_i | input | 1 | 1: open-drain pin, 0: push-pull |
| cfg_baud_div_i | input | DIVW | Bit interval minus one, in clock cycles |
| bclk_i | input | 1 | External bit clock |
| rts_ni | input | 1 | Request-to-send, low enables frame starts |
| txd_o | output | 1 | Serial pin data |
| txd_oe_o | output | 1 | Serial pin output enable |
| dac_tick_i | input | 1 | DAC update strobe |
| susp_ni | input | 1 | Suspend DAC path when low |
| dac_sample_o | output | SMP_W | DAC sample register |
| dac_sync_o | output | 1 | Toggles on each DAC update |

## Verification
A read pointer that skips or repeats shows up at the ports within one frame or one DAC update. It appears as a wrong byte on the pin or a wrong value beside a sync toggle. A bad bit counter or shift register corrupts the stop bit or the bit order of the next frame. A wrong edge select or a wrong divider shows up at the first line transition after the bit-clock edge or the interval boundary. A lost full flag lets a write overrun an unread slot. That shows up as a substituted sample on the slower path DEPTH samples later.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;
  typedef enum logic {
    LINE_PUSH_PULL  = 1'b0,
    LINE_OPEN_DRAIN = 1'b1
  } drive_e;

  typedef struct packed {
    logic   async_mode;
    logic   fall_edge;
    drive_e drive;
  } sat_cfg_t;

  localparam int unsigned RD_SER = 0;
  localparam int unsigned RD_DAC = 1;
  localparam int unsigned N_RD   = 2;
endpackage

// File: rtl/sat_sample_buf.sv
`timescale 1ns/1ps
// One write port, NRD independent readers; a slot is free once every reader passed it.
module sat_sample_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,   // power of two, >= 2
  parameter int NRD   = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              in_valid_i,
  input  logic [DW-1:0]                     in_data_i,
  output logic                              in_ready_o,
  input  logic [NRD-1:0]                    pop_i,
  output logic [NRD-1:0]                    avail_o,
  output logic [NRD-1:0][DW-1:0]            rd_data_o,
  output logic [NRD-1:0][$clog2(DEPTH):0]   lvl_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);

  logic [DW-1:0]  mem [DEPTH];
  logic [AW:0]    wr_ptr;
  logic [NRD-1:0] full;
  logic           push;

  assign in_ready_o = ~|full;
  assign push       = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wr_ptr <= '0;
    else if (push) wr_ptr <= wr_ptr + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[wr_ptr[AW-1:0]] <= in_data_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [AW:0] rd_ptr;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rd_ptr <= '0;
      else if (pop_i[g]) rd_ptr <= rd_ptr + 1'b1;
    end
    assign lvl_o[g]     = wr_ptr - rd_ptr;
    assign avail_o[g]   = (wr_ptr != rd_ptr);
    assign full[g]      = (lvl_o[g] == LVL_FULL);
    assign rd_data_o[g] = mem[rd_ptr[AW-1:0]];
  end
endmodule

// File: rtl/sat_bit_timer.sv
`timescale 1ns/1ps
module sat_bit_timer import sat_pkg::*; #(
  parameter int DIVW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  sat_cfg_t        cfg_i,
  input  logic [DIVW-1:0] div_i,
  input  logic            bclk_i,
  output logic            tick_o
);
  logic [2:0]      bclk_q;   // [0],[1] synchroniser, [2] edge history
  logic [DIVW-1:0] div_cnt;
  logic            div_hit, rise, fall;

  assign div_hit = (div_cnt >= div_i);  // >= tolerates a divider lowered mid-count
  assign rise    =  bclk_q[1] & ~bclk_q[2];
  assign fall    = ~bclk_q[1] &  bclk_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= '0;
      div_cnt <= '0;
    end else begin
      bclk_q  <= {bclk_q[1:0], bclk_i};
      div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
    end
  end

  assign tick_o = cfg_i.async_mode ? div_hit : (cfg_i.fall_edge ? fall : rise);
endmodule

// File: rtl/sat_ser_tx.sv
`timescale 1ns/1ps
module sat_ser_tx #(
  parameter int SMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             avail_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic             rts_ni,
  output logic             pop_o,
  output logic             busy_o,
  output logic             line_o
);
  localparam int FL = SMP_W + 2;
  localparam int CW = $clog2(FL);

  logic [FL-1:0] shreg;
  logic [CW-1:0] left;
  logic          at_bound;

  // rts_ni only consulted here, i.e. between frames
  assign at_bound = !busy_o || (left == '0);
  assign pop_o    = tick_i && at_bound && avail_i && !rts_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg  <= '1;
      left   <= '0;
      busy_o <= 1'b0;
    end else if (tick_i) begin
      if (pop_o) begin
        shreg  <= {1'b1, data_i, 1'b0};
        left   <= CW'(FL - 1);
        busy_o <= 1'b1;
      end else if (!at_bound) begin
        shreg  <= {1'b1, shreg[FL-1:1]};
        left   <= left - 1'b1;
      end else begin
        busy_o <= 1'b0;
      end
    end
  end

  assign line_o = busy_o ? shreg[0] : 1'b1;
endmodule

// File: rtl/sat_dac_path.sv
`timescale 1ns/1ps
module sat_dac_path #(
  parameter int SMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             susp_ni,
  input  logic             avail_i,
  input  logic [SMP_W-1:0] data_i,
  output logic             pop_o,
  output logic [SMP_W-1:0] sample_o,
  output logic             sync_o
);
  assign pop_o = tick_i && susp_ni && avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      sync_o   <= 1'b0;
    end else if (pop_o) begin
      sample_o <= data_i;
      sync_o   <= ~sync_o;
    end
  end
endmodule

// File: rtl/serial_audio_tx.sv
`timescale 1ns/1ps
module serial_audio_tx import sat_pkg::*; #(
  parameter int SMP_W = 8,
  parameter int DEPTH = 8,
  parameter int DIVW  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  output logic             smp_ready_o,
  input  logic             cfg_async_i,
  input  logic             cfg_fall_edge_i,
  input  logic             cfg_open_drain_i,
  input  logic [DIVW-1:0]  cfg_baud_div_i,
  input  logic             bclk_i,
  input  logic             rts_ni,
  output logic             txd_o,
  output logic             txd_oe_o,
  input  logic             dac_tick_i,
  input  logic             susp_ni,
  output logic [SMP_W-1:0] dac_sample_o,
  output logic             dac_sync_o
);
  localparam int LW = $clog2(DEPTH) + 1;

  sat_cfg_t                    cfg;
  logic [N_RD-1:0]             pop, avail;
  logic [N_RD-1:0][SMP_W-1:0]  rd_data;
  logic [N_RD-1:0][LW-1:0]     buf_lvl;
  logic                        bit_tick, ser_busy, ser_line;

  assign cfg = '{async_mode: cfg_async_i,
                 fall_edge:  cfg_fall_edge_i,
                 drive:      drive_e'(cfg_open_drain_i)};

  sat_sample_buf #(.DW(SMP_W), .DEPTH(DEPTH), .NRD(N_RD)) u_buf (
    .clk_i, .rst_ni,
    .in_valid_i (smp_valid_i),
    .in_data_i  (smp_data_i),
    .in_ready_o (smp_ready_o),
    .pop_i      (pop),
    .avail_o    (avail),
    .rd_data_o  (rd_data),
    .lvl_o      (buf_lvl)
  );

  sat_bit_timer #(.DIVW(DIVW)) u_timer (
    .clk_i, .rst_ni,
    .cfg_i  (cfg),
    .div_i  (cfg_baud_div_i),
    .bclk_i (bclk_i),
    .tick_o (bit_tick)
  );

  sat_ser_tx #(.SMP_W(SMP_W)) u_ser (
    .clk_i, .rst_ni,
    .tick_i  (bit_tick),
    .avail_i (avail[RD_SER]),
    .data_i  (rd_data[RD_SER]),
    .rts_ni  (rts_ni),
    .pop_o   (pop[RD_SER]),
    .busy_o  (ser_busy),
    .line_o  (ser_line)
  );

  sat_dac_path #(.SMP_W(SMP_W)) u_dac (
    .clk_i, .rst_ni,
    .tick_i   (dac_tick_i),
    .susp_ni  (susp_ni),
    .avail_i  (avail[RD_DAC]),
    .data_i   (rd_data[RD_DAC]),
    .pop_o    (pop[RD_DAC]),
    .sample_o (dac_sample_o),
    .sync_o   (dac_sync_o)
  );

  always_comb begin
    if (cfg.drive == LINE_OPEN_DRAIN) begin
      txd_o    = 1'b0;
      txd_oe_o = ~ser_line;
    end else begin
      txd_o    = ser_line;
      txd_oe_o = 1'b1;
    end
  end
endmodule

// File: rtl/sat_checker.sv
`timescale 1ns/1ps
module sat_checker #(
  parameter int SMP_W = 8,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rts_ni,
  input logic             susp_ni,
  input logic             dac_tick_i,
  input logic [SMP_W-1:0] dac_sample_o,
  input logic             dac_sync_o,
  input logic             ser_busy,
  input logic             ser_line,
  input logic [1:0][LW-1:0] buf_lvl
);
  AST_SUSP_HOLDS_DAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !susp_ni |=> $stable(dac_sample_o)); // R8

  AST_SYNC_MARKS_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_sample_o) |-> !$stable(dac_sync_o)); // R9

  AST_SYNC_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_sync_o) |-> $past(dac_tick_i && susp_ni)); // R9

  AST_START_NEEDS_RTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_busy) |-> $past(!rts_ni)); // R5

  AST_STOP_BEFORE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_busy) |-> $past(ser_line)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_lvl[0] <= LW'(DEPTH)) && (buf_lvl[1] <= LW'(DEPTH))); // R11
endmodule

bind serial_audio_tx sat_checker #(
  .SMP_W(SMP_W), .DEPTH(DEPTH), .LW($clog2(DEPTH) + 1)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rts_ni       (rts_ni),
  .susp_ni      (susp_ni),
  .dac_tick_i   (dac_tick_i),
  .dac_sample_o (dac_sample_o),
  .dac_sync_o   (dac_sync_o),
  .ser_busy     (ser_busy),
  .ser_line     (ser_line),
  .buf_lvl      (buf_lvl)
);

// File: tb/sim_serial_audio_tx.sv
`timescale 1ns/1ps
module sim_serial_audio_tx;
  localparam int SMP_W = 8;
  localparam int DEPTH = 8;
  localparam int DIVW  = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             smp_valid = 1'b0;
  logic [SMP_W-1:0] smp_data = '0;
  logic             smp_ready;
  logic             cfg_async = 1'b1, cfg_fall = 1'b0, cfg_od = 1'b0;
  logic [DIVW-1:0]  cfg_div = DIVW'(3);
  logic             bclk = 1'b0;
  logic             rts_n = 1'b0;
  logic             txd, txd_oe;
  logic             dac_tick = 1'b0;
  logic             susp_n = 1'b1;
  logic [SMP_W-1:0] dac_sample;
  logic             dac_sync;
  logic             pin;

  assign pin = txd_oe ? txd : 1'b1;  // external pull-up

  serial_audio_tx #(.SMP_W(SMP_W), .DEPTH(DEPTH), .DIVW(DIVW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .smp_ready_o(smp_ready),
    .cfg_async_i(cfg_async), .cfg_fall_edge_i(cfg_fall), .cfg_open_drain_i(cfg_od),
    .cfg_baud_div_i(cfg_div), .bclk_i(bclk), .rts_ni(rts_n),
    .txd_o(txd), .txd_oe_o(txd_oe),
    .dac_tick_i(dac_tick), .susp_ni(susp_n),
    .dac_sample_o(dac_sample), .dac_sync_o(dac_sync)
  );

  int errors = 0, checks = 0;
  logic [7:0] exp_ser[$], exp_dac[$];
  int rx_st = 0, rx_n = 0, frames = 0;
  logic [7:0] rx_byte;
  int cyc = 0, last_chg = 0, since_act = 0, bclk_cnt = 0, tick_cnt = 0;
  bit chg_valid = 0, hold_idle = 0, mon_en = 0;
  logic prev_pin = 1'b1, prev_sync = 1'b0;
  logic [7:0] prev_dac = '0;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  // deframer shared by both timing modes
  function automatic void feed(logic b);
    logic [7:0] e;
    if (rx_st == 0) begin
      if (!b) begin rx_st = 1; rx_n = 0; end
    end else if (rx_st == 1) begin
      rx_byte[rx_n] = b;
      rx_n++;
      if (rx_n == 8) rx_st = 2;
    end else begin
      chk(b == 1'b1, "R2", "stop bit", int'(b), 1);
      if (exp_ser.size() == 0) chk(0, "R7", "unexpected frame", int'(rx_byte), -1);
      else begin
        e = exp_ser.pop_front();
        chk(rx_byte == e, "R7", "serial byte", int'(rx_byte), int'(e));
      end
      frames++;
      rx_st = 0;
    end
  endfunction

  // per-cycle monitor, bit clock and DAC tick generation
  always @(negedge clk) begin
    logic nxt;
    logic [7:0] e;
    if (rst_n && mon_en) begin
      cyc++;
      since_act++;
      if (cfg_od) chk(!(txd_oe && txd), "R6", "open-drain drives high", int'(txd), 0);
      else        chk(txd_oe == 1'b1, "R6", "push-pull enable", int'(txd_oe), 1);
      if (pin != prev_pin) begin
        if (cfg_async) begin
          if (chg_valid)
            chk(((cyc - last_chg) % (int'(cfg_div) + 1)) == 0, "R3", "edge off bit grid",
                cyc - last_chg, int'(cfg_div) + 1);
          last_chg = cyc;
          chg_valid = 1;
        end else begin
          chk(since_act <= 4, "R4", "cycles after active edge", since_act, 4);
        end
      end
      if (hold_idle) chk(pin == 1'b1, "R5", "line while rts high", int'(pin), 1);
      if (dac_sync != prev_sync) begin
        if (exp_dac.size() == 0) chk(0, "R9", "sync toggle without sample", int'(dac_sample), -1);
        else begin
          e = exp_dac.pop_front();
          chk(dac_sample == e, "R7", "dac sample", int'(dac_sample), int'(e));
        end
      end else if (dac_sample != prev_dac) begin
        chk(0, "R9", "dac change without sync", int'(dac_sample), int'(prev_dac));
      end
      prev_pin  = pin;
      prev_sync = dac_sync;
      prev_dac  = dac_sample;
    end
    bclk_cnt++;
    if (bclk_cnt == 8) begin
      bclk_cnt = 0;
      nxt = ~bclk;
      if (nxt == ~cfg_fall) begin
        if (rst_n && mon_en && !cfg_async) feed(pin);
        since_act = 0;
      end
      bclk = nxt;
    end
    tick_cnt++;
    if (tick_cnt == 5) begin tick_cnt = 0; dac_tick = 1'b1; end
    else dac_tick = 1'b0;
  end

  // asynchronous-mode receiver, mid-bit sampling
  initial begin
    int per;
    forever begin
      @(negedge clk);
      if (rst_n && mon_en && cfg_async && pin == 1'b0 && rx_st == 0) begin
        per = int'(cfg_div) + 1;
        repeat (per / 2) @(negedge clk);
        chk(pin == 1'b0, "R2", "start bit", int'(pin), 0);
        feed(pin);
        for (int i = 0; i < 9; i++) begin
          repeat (per) @(negedge clk);
          feed(pin);
        end
      end
    end
  end

  task automatic push(input logic [7:0] d);
    bit ok = 0;
    while (!ok) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = d;
      ok = smp_ready;
    end
    exp_ser.push_back(d);
    exp_dac.push_back(d);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic try_push(input logic [7:0] d, output bit ok);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = d;
    ok = smp_ready;
    @(negedge clk);
    smp_valid = 1'b0;
    if (ok) begin exp_ser.push_back(d); exp_dac.push_back(d); end
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_ser.size() != 0 || exp_dac.size() != 0 || rx_st != 0) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (40) @(negedge clk);
    chk(exp_ser.size() == 0, req, "serial backlog", exp_ser.size(), 0);
    chk(exp_dac.size() == 0, "R7", "dac backlog", exp_dac.size(), 0);
    chk(pin == 1'b1, "R10", "idle line", int'(pin), 1);
  endtask

  task automatic set_mode(input bit a, input bit f, input bit od, input int div);
    @(negedge clk);
    cfg_async = a; cfg_fall = f; cfg_od = od; cfg_div = DIVW'(div);
    chg_valid = 0;
    rx_st = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 20)) @(negedge clk);
      push(8'($urandom_range(0, 255)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", cyc, -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f0, acc, n;
    bit ok;
    logic s0;
    void'($urandom(32'h5eed_a0d1));
    repeat (4) @(negedge clk);
    chk(pin == 1'b1,       "R1", "pin in reset", int'(pin), 1);
    chk(txd_oe == 1'b1,    "R1", "oe in reset", int'(txd_oe), 1);
    chk(dac_sample == 0,   "R1", "dac in reset", int'(dac_sample), 0);
    chk(dac_sync == 1'b0,  "R1", "sync in reset", int'(dac_sync), 0);
    chk(smp_ready == 1'b1, "R1", "ready in reset", int'(smp_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1;

    set_mode(1, 0, 0, 3);          run_rand(20); drain("R2");
    set_mode(1, 0, 1, 6);          run_rand(12); drain("R6");
    set_mode(0, 0, 0, 3);          run_rand(10); drain("R4");
    set_mode(0, 1, 1, 3);          run_rand(10); drain("R4");

    // R5: hold-off at boundary, in-progress frame completes
    set_mode(1, 0, 0, 3);
    @(negedge clk); rts_n = 1'b1; hold_idle = 1;
    f0 = frames;
    push(8'h3C);
    repeat (200) @(negedge clk);
    hold_idle = 0;
    chk(frames == f0, "R5", "frames while rts high", frames - f0, 0);
    rts_n = 1'b0;
    drain("R5");
    push(8'hC3); push(8'h5A);
    n = 0;
    while (pin == 1'b1 && n < 500) begin @(negedge clk); n++; end
    rts_n = 1'b1;
    f0 = frames;
    repeat (300) @(negedge clk);
    chk(frames == f0 + 1, "R5", "frames after mid-frame rts high", frames - f0, 1);
    chk(exp_ser.size() == 1, "R5", "held bytes", exp_ser.size(), 1);
    rts_n = 1'b0;
    drain("R5");

    // R8: suspend freezes DAC only
    @(negedge clk); susp_n = 1'b0;
    s0 = dac_sync;
    f0 = frames;
    push(8'h11); push(8'h22); push(8'h33);
    n = 0;
    while ((exp_ser.size() != 0 || rx_st != 0) && n < 3000) begin @(negedge clk); n++; end
    chk(frames == f0 + 3, "R8", "serial frames during suspend", frames - f0, 3);
    chk(dac_sync == s0, "R8", "sync during suspend", int'(dac_sync), int'(s0));
    chk(exp_dac.size() == 3, "R8", "dac backlog during suspend", exp_dac.size(), 3);
    susp_n = 1'b1;
    drain("R8");

    // R11: backpressure from either reader
    @(negedge clk); rts_n = 1'b1; susp_n = 1'b0;
    acc = 0;
    for (int i = 0; i < DEPTH + 3; i++) begin
      try_push(8'(8'h40 + i), ok);
      if (ok) acc++;
    end
    chk(acc == DEPTH, "R11", "accepted before full", acc, DEPTH);
    chk(smp_ready == 1'b0, "R11", "ready when full", int'(smp_ready), 0);
    rts_n = 1'b0;
    n = 0;
    while ((exp_ser.size() != 0 || rx_st != 0) && n < 3000) begin @(negedge clk); n++; end
    chk(smp_ready == 1'b0, "R11", "ready with dac reader full", int'(smp_ready), 0);
    susp_n = 1'b1;
    drain("R11");

    // corner bytes at the fastest bit rate, back to back
    set_mode(1, 0, 0, 0);
    push(8'h00); push(8'hFF); push(8'h80); push(8'h01); push(8'hA5);
    drain("R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule